// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker

This engine moves data between an on-chip byte buffer and host memory. The host describes where the data goes as a table of region descriptors. The engine reads the table one descriptor at a time. It decodes each entry into a start address, a byte length and an end-of-table marker. It then issues word-wide memory beats of up to four bytes until either the buffer or the table is used up.

A call begins with a one-cycle `go` pulse that carries the byte count of the buffer and the transfer direction. With `fresh` set, the call begins a new command: it forgets any partly used descriptor and restarts the table walk at `tbl_base`. With `fresh` clear, the call carries on from the exact descriptor position where the previous call stopped, so one table can feed a transfer made of several buffer loads. Each call ends with one pulse on either `done_ok` (the buffer was drained) or `done_early` (the table ran out first). The pulse is dropped if the call is cut short by `abort`.

Top module: `prdw_walker`

## Requirements
- R1: A descriptor is two little-endian 32-bit words read at the fetch pointer: the region address at offset 0, then the size/flags word at offset 4. After both words are read, the fetch pointer moves on by 8.
- R2: The region length is the low 16 bits of the size/flags word with bit 0 forced to zero. Bits 30..16 are ignored, and a resulting value of zero stands for 65536 bytes.
- R3: Bit 31 of the size/flags word marks the final descriptor. Once that region is used up, no further descriptor is fetched.
- R4: When the current region is used up and the fetch pointer is `PAGE_BYTES` or more past the table base, the walk ends as if the end flag had been seen.
- R5: Each data beat moves the smallest of 4, the bytes left in the buffer and the bytes left in the region. Its enables are the lowest lanes (0001, 0011, 0111 or 1111). The region address advances by the beat size, and the region's remaining length and the buffer index change by the same amount.
- R6: With `dir`=1, buffer bytes are written to host memory. With `dir`=0, host bytes are read into the buffer. Nothing is written on the other side.
- R7: A call ends with exactly one pulse: `done_ok` if the buffer is drained, even when the table ends at the same moment, otherwise `done_early`. `buf_idx` then holds the number of bytes moved.
- R8: `go` with `fresh`=0 resumes at the saved descriptor position and fetch pointer. `go` with `fresh`=1 clears the region state and fetches first from `tbl_base`.
- R9: After `abort`, the engine returns to idle in the cycle after the outstanding memory handshake completes, or at once if none is outstanding. No done pulse is given.
- R10: While `mem_req` is high and `mem_ready` is low, the request, address, write flag and enables hold steady.
- R11: During and after reset the engine is idle, with no memory request, no buffer write and no done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start a call; accepted only while idle |
| fresh | input | 1 | With `go`: begin a new command from the table base |
| dir | input | 1 | With `go`: 1 = buffer to host, 0 = host to buffer |
| abort | input | 1 | Stop the current call |
| tbl_base | input | AW | Table base address, sampled at a fresh `go` |
| buf_size | input | IDX_W | Bytes in the buffer for this call |
| busy | output | 1 | A call is in progress |
| done_ok | output | 1 | Pulse: buffer drained |
| done_early | output | 1 | Pulse: table ended before the buffer drained |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address of the beat |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Write data, byte lane 0 at the address |
| mem_rdata | input | 32 | Read data, valid when `mem_ready` is high |
| mem_ready | input | 1 | Completes the current request |
| buf_idx | output | IDX_W | Current buffer byte index |
| buf_we | output | 1 | Buffer write strobe |
| buf_be | output | 4 | Buffer lane enables |
| buf_wdata | output | 32 | Data to the buffer at `buf_idx` |
| buf_rdata | input | 32 | Buffer data at `buf_idx` |

## Verification
The bench builds the engine with `PAGE_BYTES`=64, so the table safety limit trips after only eight descriptors and a table with no end flag can be walked to its limit in a few dozen cycles. `IDX_W` stays at 17, so a buffer of 65540 bytes can run a zero-length (64 KiB) region to completion. With these values, every buffer size from 0 to 30 is swept in both directions against a three-entry table with odd size words. The sweep covers every tail width, every descriptor boundary and the tie between a drained buffer and the end of the table.

// File: rtl/prdw_pkg.sv
package prdw_pkg;
  localparam int BEAT_B      = 4;
  localparam int WORD_W      = 8 * BEAT_B;
  localparam int DESC_BYTES  = 8;
  localparam int LEN_FIELD_W = 16;
  localparam int END_BIT     = 31;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CHECK = 3'd1,
    ST_FADDR = 3'd2,
    ST_FSIZE = 3'd3,
    ST_XFER  = 3'd4
  } walk_st_e;
endpackage

// File: rtl/prdw_size_decode.sv
module prdw_size_decode
  import prdw_pkg::*;
#(
  parameter int LEN_W = LEN_FIELD_W + 1
) (
  input  logic [WORD_W-1:0] size_word,
  output logic [LEN_W-1:0]  len,
  output logic              is_final
);
  logic [LEN_FIELD_W-1:0] masked;

  // bit 0 never counts: region lengths are even
  assign masked   = size_word[LEN_FIELD_W-1:0] & ~LEN_FIELD_W'(1);
  assign len      = (masked == '0) ? (LEN_W'(1) << LEN_FIELD_W) : LEN_W'(masked);
  assign is_final = size_word[END_BIT];
endmodule

// File: rtl/prdw_beat_sizer.sv
module prdw_beat_sizer
  import prdw_pkg::*;
#(
  parameter int IDX_W = 17,
  parameter int LEN_W = 17,
  parameter int NB_W  = $clog2(BEAT_B + 1)
) (
  input  logic [IDX_W-1:0]  buf_left,
  input  logic [LEN_W-1:0]  reg_left,
  output logic [NB_W-1:0]   nbytes,
  output logic [BEAT_B-1:0] lanes
);
  logic [NB_W-1:0] buf_cap;
  logic [NB_W-1:0] reg_cap;

  assign buf_cap = (buf_left >= IDX_W'(BEAT_B)) ? NB_W'(BEAT_B) : buf_left[NB_W-1:0];
  assign reg_cap = (reg_left >= LEN_W'(BEAT_B)) ? NB_W'(BEAT_B) : reg_left[NB_W-1:0];
  assign nbytes  = (buf_cap < reg_cap) ? buf_cap : reg_cap;

  for (genvar g = 0; g < BEAT_B; g++) begin : g_lane
    assign lanes[g] = (nbytes > NB_W'(g));
  end
endmodule

// File: rtl/prdw_end_check.sv
module prdw_end_check #(
  parameter int AW         = 32,
  parameter int PAGE_BYTES = 4096
) (
  input  logic [AW-1:0] fetch_ptr,
  input  logic [AW-1:0] base,
  input  logic          saw_final,
  output logic          tbl_stop
);
  logic [AW-1:0] span;

  assign span     = fetch_ptr - base;
  assign tbl_stop = saw_final || (span >= AW'(PAGE_BYTES));
endmodule

// File: rtl/prdw_walker.sv
module prdw_walker
  import prdw_pkg::*;
#(
  parameter int AW         = 32,
  parameter int IDX_W      = 17,
  parameter int PAGE_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              fresh,
  input  logic              dir,
  input  logic              abort,
  input  logic [AW-1:0]     tbl_base,
  input  logic [IDX_W-1:0]  buf_size,
  output logic              busy,
  output logic              done_ok,
  output logic              done_early,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [BEAT_B-1:0] mem_be,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic [IDX_W-1:0]  buf_idx,
  output logic              buf_we,
  output logic [BEAT_B-1:0] buf_be,
  output logic [WORD_W-1:0] buf_wdata,
  input  logic [WORD_W-1:0] buf_rdata
);
  localparam int LEN_W = LEN_FIELD_W + 1;
  localparam int NB_W  = $clog2(BEAT_B + 1);

  walk_st_e          st_q, st_d;
  logic [AW-1:0]     ptr_q, ptr_d;
  logic [AW-1:0]     base_q, base_d;
  logic [AW-1:0]     raddr_q, raddr_d;
  logic [LEN_W-1:0]  rrem_q, rrem_d;
  logic              rfinal_q, rfinal_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [IDX_W-1:0]  size_q, size_d;
  logic              dir_q, dir_d;
  logic              abt_q, abt_d;
  logic              ok_q, ok_d;
  logic              early_q, early_d;

  logic [LEN_W-1:0]  dec_len;
  logic              dec_final;
  logic [IDX_W-1:0]  buf_left;
  logic [NB_W-1:0]   nbytes;
  logic [BEAT_B-1:0] lanes;
  logic              tbl_stop;
  logic              drained;
  logic              abt_hit;
  logic              beat_done;
  logic              more_beats;

  prdw_size_decode #(.LEN_W(LEN_W)) u_dec (
    .size_word (mem_rdata),
    .len       (dec_len),
    .is_final  (dec_final)
  );

  prdw_beat_sizer #(.IDX_W(IDX_W), .LEN_W(LEN_W), .NB_W(NB_W)) u_sizer (
    .buf_left (buf_left),
    .reg_left (rrem_q),
    .nbytes   (nbytes),
    .lanes    (lanes)
  );

  prdw_end_check #(.AW(AW), .PAGE_BYTES(PAGE_BYTES)) u_end (
    .fetch_ptr (ptr_q),
    .base      (base_q),
    .saw_final (rfinal_q),
    .tbl_stop  (tbl_stop)
  );

  assign buf_left   = size_q - idx_q;
  assign drained    = (idx_q >= size_q);
  assign abt_hit    = abort || abt_q;
  assign beat_done  = mem_req && mem_ready;
  assign more_beats = (rrem_q > LEN_W'(nbytes)) && (buf_left > IDX_W'(nbytes));

  // memory and buffer side outputs, decoded from the state
  always_comb begin
    mem_req  = (st_q == ST_FADDR) || (st_q == ST_FSIZE) || (st_q == ST_XFER);
    mem_we   = (st_q == ST_XFER) && dir_q;
    mem_be   = (st_q == ST_XFER) ? lanes : '1;
    unique case (st_q)
      ST_FADDR: mem_addr = ptr_q;
      ST_FSIZE: mem_addr = ptr_q + AW'(BEAT_B);
      default:  mem_addr = raddr_q;
    endcase
    mem_wdata = buf_rdata;
    buf_we    = (st_q == ST_XFER) && !dir_q && mem_ready;
    buf_be    = lanes;
    buf_wdata = mem_rdata;
  end

  // next-state logic
  always_comb begin
    st_d     = st_q;
    ptr_d    = ptr_q;
    base_d   = base_q;
    raddr_d  = raddr_q;
    rrem_d   = rrem_q;
    rfinal_d = rfinal_q;
    idx_d    = idx_q;
    size_d   = size_q;
    dir_d    = dir_q;
    abt_d    = abt_q || abort;
    ok_d     = 1'b0;
    early_d  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        abt_d = 1'b0;
        if (go) begin
          size_d = buf_size;
          idx_d  = '0;
          dir_d  = dir;
          if (fresh) begin
            raddr_d  = '0;
            rrem_d   = '0;
            rfinal_d = 1'b0;
            ptr_d    = tbl_base;
            base_d   = tbl_base;
          end
          st_d = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (abt_hit) begin
          st_d = ST_IDLE;
        end else if (drained) begin
          st_d = ST_IDLE;
          ok_d = 1'b1;
        end else if (rrem_q == '0) begin
          if (tbl_stop) begin
            st_d    = ST_IDLE;
            early_d = 1'b1;
          end else begin
            st_d = ST_FADDR;
          end
        end else begin
          st_d = ST_XFER;
        end
      end
      ST_FADDR: begin
        if (beat_done) begin
          raddr_d = AW'(mem_rdata);
          st_d    = abt_hit ? ST_IDLE : ST_FSIZE;
        end
      end
      ST_FSIZE: begin
        if (beat_done) begin
          rrem_d   = dec_len;
          rfinal_d = dec_final;
          ptr_d    = ptr_q + AW'(DESC_BYTES);
          st_d     = abt_hit ? ST_IDLE : ST_CHECK;
        end
      end
      ST_XFER: begin
        if (beat_done) begin
          raddr_d = raddr_q + AW'(nbytes);
          rrem_d  = rrem_q - LEN_W'(nbytes);
          idx_d   = idx_q + IDX_W'(nbytes);
          if (abt_hit)         st_d = ST_IDLE;
          else if (more_beats) st_d = ST_XFER;
          else                 st_d = ST_CHECK;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      ptr_q    <= '0;
      base_q   <= '0;
      raddr_q  <= '0;
      rrem_q   <= '0;
      rfinal_q <= 1'b0;
      idx_q    <= '0;
      size_q   <= '0;
      dir_q    <= 1'b0;
      abt_q    <= 1'b0;
      ok_q     <= 1'b0;
      early_q  <= 1'b0;
    end else begin
      st_q     <= st_d;
      ptr_q    <= ptr_d;
      base_q   <= base_d;
      raddr_q  <= raddr_d;
      rrem_q   <= rrem_d;
      rfinal_q <= rfinal_d;
      idx_q    <= idx_d;
      size_q   <= size_d;
      dir_q    <= dir_d;
      abt_q    <= abt_d;
      ok_q     <= ok_d;
      early_q  <= early_d;
    end
  end

  assign busy       = (st_q != ST_IDLE);
  assign done_ok    = ok_q;
  assign done_early = early_q;
  assign buf_idx    = idx_q;
endmodule

// File: rtl/prdw_walker_chk.sv
module prdw_walker_chk #(
  parameter int AW    = 32,
  parameter int IDX_W = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic             abort,
  input logic             busy,
  input logic             done_ok,
  input logic             done_early,
  input logic             mem_req,
  input logic             mem_we,
  input logic             mem_ready,
  input logic [AW-1:0]    mem_addr,
  input logic [3:0]       mem_be,
  input logic             buf_we,
  input logic [IDX_W-1:0] buf_idx
);
  logic ab_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ab_pend <= 1'b0;
    else if (!busy) ab_pend <= 1'b0;
    else if (abort) ab_pend <= 1'b1;
  end

  // R10: a waiting request holds its fields
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_be));

  // R5: enables fill the lowest lanes
  p_lanes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_be == 4'b0001 || mem_be == 4'b0011 || mem_be == 4'b0111 || mem_be == 4'b1111));

  // R5: the buffer index never moves backwards within a call
  p_idx_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> buf_idx >= $past(buf_idx));

  // R6: buffer is written only by a completed host read
  p_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> mem_req && mem_ready && !mem_we);

  // R7: one outcome, one cycle, reported while idle
  p_one_outcome_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_ok && done_early));
  p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ok || done_early) |-> !busy ##1 !(done_ok || done_early));

  // R9: abort takes effect right after the handshake
  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (abort || ab_pend) && (!mem_req || mem_ready) |=> !busy && !done_ok && !done_early);

  // R11: an idle engine makes no request
  p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !buf_we);
endmodule

bind prdw_walker prdw_walker_chk #(.AW(AW), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .abort      (abort),
  .busy       (busy),
  .done_ok    (done_ok),
  .done_early (done_early),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_ready  (mem_ready),
  .mem_addr   (mem_addr),
  .mem_be     (mem_be),
  .buf_we     (buf_we),
  .buf_idx    (buf_idx)
);

// File: tb/prdw_walker_tb.sv
`timescale 1ns/1ps
module prdw_walker_tb;
  localparam int AW = 32;
  localparam int IDX_W = 17;
  localparam int PAGE = 64;
  localparam int MEMSZ = 1 << 17;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, go, fresh, dir, abort;
  logic [AW-1:0] tbl_base;
  logic [IDX_W-1:0] buf_size;
  logic busy, done_ok, done_early, mem_req, mem_we, mem_ready, buf_we;
  logic [AW-1:0] mem_addr;
  logic [3:0] mem_be, buf_be;
  logic [31:0] mem_wdata, mem_rdata, buf_wdata, buf_rdata;
  logic [IDX_W-1:0] buf_idx;

  prdw_walker #(.AW(AW), .IDX_W(IDX_W), .PAGE_BYTES(PAGE)) u_dut (
    .clk(clk), .rst_n(rst_n), .go(go), .fresh(fresh), .dir(dir), .abort(abort),
    .tbl_base(tbl_base), .buf_size(buf_size), .busy(busy), .done_ok(done_ok),
    .done_early(done_early), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .buf_idx(buf_idx), .buf_we(buf_we), .buf_be(buf_be), .buf_wdata(buf_wdata),
    .buf_rdata(buf_rdata)
  );

  logic [7:0] hmem [0:MEMSZ-1];
  logic [7:0] bmem [0:MEMSZ-1];
  logic [7:0] exph [0:MEMSZ-1];
  logic [7:0] expb [0:MEMSZ-1];
  int map [0:65599];

  int total = 0, bad = 0, salt = 0;
  int d_addr [0:8];
  int unsigned d_size [0:8];
  int unsigned e_ptr, e_cur, e_rem, e_base;
  bit e_last;
  int first_addr, hold_viol = 0;

  // memory model with pseudo-random wait states
  logic [7:0] lfsr = 8'h1;
  logic [1:0] stall_q = 2'd0;
  logic stall_en = 1'b1;
  logic fill_go = 1'b0, tbl_go = 1'b0;
  int fill_lo = 0, fill_hi = 0, fill_bn = 0;
  wire [16:0] ha = mem_addr[16:0];
  wire [16:0] ba = buf_idx;

  function automatic logic [7:0] pa(int a, int s);
    return 8'(a ^ (a >> 8) ^ (s * 13));
  endfunction
  function automatic logic [7:0] pb(int k, int s);
    return 8'(k * 7 + 3 + s * 29);
  endfunction

  assign mem_ready = mem_req && (stall_q == 2'd0);
  assign mem_rdata = {hmem[ha + 17'd3], hmem[ha + 17'd2], hmem[ha + 17'd1], hmem[ha]};
  assign buf_rdata = {bmem[ba + 17'd3], bmem[ba + 17'd2], bmem[ba + 17'd1], bmem[ba]};

  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (mem_req && mem_ready) stall_q <= stall_en ? lfsr[1:0] : 2'd0;
    else if (stall_q != 2'd0) stall_q <= stall_q - 2'd1;
    if (fill_go) begin
      for (int a = fill_lo; a < fill_hi; a++) hmem[a] <= pa(a, salt);
      for (int k = 0; k < fill_bn; k++) bmem[k] <= pb(k, salt);
    end
    if (tbl_go) begin
      for (int j = 0; j < 9; j++) begin
        for (int b = 0; b < 4; b++) begin
          hmem[e_base + 8*j + b]     <= 8'(d_addr[j] >> (8*b));
          hmem[e_base + 8*j + 4 + b] <= 8'(d_size[j] >> (8*b));
        end
      end
    end
    if (mem_req && mem_ready && mem_we)
      for (int i = 0; i < 4; i++) if (mem_be[i]) hmem[ha + 17'(i)] <= mem_wdata[8*i +: 8];
    if (buf_we)
      for (int i = 0; i < 4; i++) if (buf_be[i]) bmem[ba + 17'(i)] <= buf_wdata[8*i +: 8];
  end

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic load_table();
    @(negedge clk); tbl_go = 1'b1;
    @(negedge clk); tbl_go = 1'b0;
  endtask

  task automatic run_case(input bit fr, input bit dr, input int sz, input int lo, input int hi, input string req);
    int moved, len, cyc, bad_at;
    bit early, seen, pw;
    int pa_q;
    salt++;
    // reference walk from the requirements
    if (fr) begin e_rem = 0; e_last = 0; e_cur = 0; e_ptr = e_base; end
    moved = 0; early = 0;
    while (moved < sz) begin
      if (e_rem == 0) begin
        if (e_last || (e_ptr - e_base) >= PAGE) begin early = 1; break; end
        e_cur  = d_addr[(e_ptr - e_base) / 8];
        len    = int'(d_size[(e_ptr - e_base) / 8] & 32'hFFFE);
        if (len == 0) len = 65536;
        e_rem  = len;
        e_last = d_size[(e_ptr - e_base) / 8][31];
        e_ptr += 8;
      end
      map[moved] = e_cur; e_cur++; e_rem--; moved++;
    end
    for (int a = lo; a < hi; a++) exph[a] = pa(a, salt);
    for (int k = 0; k < sz + 8; k++) expb[k] = pb(k, salt);
    for (int k = 0; k < moved; k++)
      if (dr) exph[map[k]] = pb(k, salt); else expb[k] = pa(map[k], salt);
    fill_lo = lo; fill_hi = hi; fill_bn = sz + 8;
    @(negedge clk); fill_go = 1'b1;
    @(negedge clk); fill_go = 1'b0;
    go = 1'b1; fresh = fr; dir = dr; buf_size = IDX_W'(sz); tbl_base = e_base;
    @(negedge clk); go = 1'b0;
    cyc = 0; seen = 0; first_addr = -1; pw = 0; pa_q = 0;
    while (!(done_ok || done_early) && cyc < 100000) begin
      @(negedge clk); cyc++;
      if (pw && (!mem_req || int'(mem_addr) != pa_q)) hold_viol++;
      pw = mem_req && !mem_ready; pa_q = int'(mem_addr);
      if (mem_req && !seen) begin seen = 1; first_addr = int'(mem_addr); end
    end
    chk(done_early == early && done_ok == !early, req, "outcome early", longint'(done_early), longint'(early));
    chk(int'(buf_idx) == moved, req, "bytes moved", longint'(buf_idx), longint'(moved));
    bad_at = -1;
    for (int a = lo; a < hi; a++) if (hmem[a] !== exph[a] && bad_at < 0) bad_at = a;
    for (int k = 0; k < sz + 8; k++) if (bmem[k] !== expb[k] && bad_at < 0) bad_at = MEMSZ + k;
    chk(bad_at < 0, req, "data mismatch at", longint'(bad_at), -1);
    @(negedge clk);
  endtask

  initial begin
    int cyc;
    bit saw_done;
    rst_n = 1'b0; go = 1'b0; fresh = 1'b0; dir = 1'b0; abort = 1'b0;
    tbl_base = '0; buf_size = '0;
    repeat (3) @(negedge clk);
    // R11: idle under reset
    chk(!busy && !mem_req && !buf_we && !done_ok && !done_early, "R11", "reset quiet", longint'(busy || mem_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_req, "R11", "idle after reset", longint'(busy), 0);

    // three-entry table: odd size words, high junk bits, end flag on the third
    e_base = 32'h100;
    d_addr[0] = 32'h1003; d_size[0] = 32'h0000_0007;
    d_addr[1] = 32'h1021; d_size[1] = 32'h0003_000A;
    d_addr[2] = 32'h1042; d_size[2] = 32'h8000_0009;
    for (int j = 3; j < 9; j++) begin d_addr[j] = 32'h1050; d_size[j] = 32'h8000_0002; end
    load_table();
    // R2 R3 R5 R6 R7: every buffer size around the 24-byte table
    for (int dr = 0; dr < 2; dr++)
      for (int sz = 0; sz <= 30; sz++)
        run_case(1'b1, dr[0], sz, 32'h1000, 32'h1060, "R2/R3/R5/R6/R7");

    // R8: resume across calls, then restart
    run_case(1'b1, 1'b1, 9, 32'h1000, 32'h1060, "R8");
    run_case(1'b0, 1'b1, 9, 32'h1000, 32'h1060, "R8");
    run_case(1'b0, 1'b0, 9, 32'h1000, 32'h1060, "R8");
    run_case(1'b1, 1'b0, 5, 32'h1000, 32'h1060, "R8");
    chk(first_addr == int'(e_base), "R8", "restart fetch address", longint'(first_addr), longint'(e_base));

    // R4: eight entries without an end flag fill the 64-byte page; a decoy follows
    e_base = 32'h200;
    for (int j = 0; j < 8; j++) begin d_addr[j] = 32'h1800 + 16*j; d_size[j] = 32'h0000_0002; end
    d_addr[8] = 32'h1808; d_size[8] = 32'h0000_0040;
    load_table();
    run_case(1'b1, 1'b1, 40, 32'h1800, 32'h1890, "R4");
    chk(first_addr == int'(e_base), "R1", "first descriptor address", longint'(first_addr), longint'(e_base));
    run_case(1'b1, 1'b0, 16, 32'h1800, 32'h1890, "R4/R7");

    // R2: masked length zero means 64 KiB
    e_base = 32'h380;
    d_addr[0] = 32'h4000; d_size[0] = 32'h8000_0001;
    for (int j = 1; j < 9; j++) begin d_addr[j] = 32'h1050; d_size[j] = 32'h8000_0002; end
    load_table();
    stall_en = 1'b0;
    run_case(1'b1, 1'b0, 65540, 32'h4000, 32'h14010, "R2");
    stall_en = 1'b1;

    // R9: abort in the middle of a long region
    e_base = 32'h300;
    d_addr[0] = 32'h2000; d_size[0] = 32'h8000_0100;
    load_table();
    @(negedge clk);
    go = 1'b1; fresh = 1'b1; dir = 1'b1; buf_size = IDX_W'(256); tbl_base = e_base;
    @(negedge clk); go = 1'b0;
    repeat (12) @(negedge clk);
    abort = 1'b1;
    @(negedge clk); abort = 1'b0;
    cyc = 0; saw_done = 0;
    while (busy && cyc < 8) begin
      if (done_ok || done_early) saw_done = 1;
      @(negedge clk); cyc++;
    end
    if (done_ok || done_early) saw_done = 1;
    chk(!busy && cyc <= 5, "R9", "cycles to idle", longint'(cyc), 5);
    chk(!saw_done, "R9", "done pulse after abort", longint'(saw_done), 0);
    chk(int'(buf_idx) < 256, "R9", "bytes moved before stop", longint'(buf_idx), 255);
    // a fresh call after the abort runs normally
    e_base = 32'h100;
    d_addr[0] = 32'h1003; d_size[0] = 32'h0000_0007;
    d_addr[1] = 32'h1021; d_size[1] = 32'h0003_000A;
    d_addr[2] = 32'h1042; d_size[2] = 32'h8000_0009;
    load_table();
    run_case(1'b1, 1'b1, 20, 32'h1000, 32'h1060, "R9");

    // R10: waiting requests never changed
    chk(hold_viol == 0, "R10", "request hold violations", longint'(hold_viol), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule